// File: doc/BRIEF.md
# Interrupt Message Destination Resolver

This block turns one decoded message-signalled interrupt into the set of local interrupt controllers that should receive it. Up to eight agents are supported by default. Each agent presents three values: its physical ID, its flat logical ID and its arbitration priority. The message supplies the following:

- an 8-bit destination field;
- a destination-mode bit, where 0 means physical and 1 means logical;
- a redirection hint bit, which comes from the message address;
- a 3-bit delivery-mode code.

In physical mode, the block selects the agent whose ID equals the destination. In logical mode, it selects every agent whose logical ID shares a set bit with the destination. When the message asks for arbitration, either through the redirection hint in logical mode or through the lowest-priority delivery code, the candidate set is narrowed to the single agent with the lowest priority class. This narrowing is done in the same pass that builds the set.

The resolved bitmask is registered and presented one cycle after the request. A flag reports that nothing matched. After resolution, a lowest-priority message is handled exactly like a fixed one: the block outputs only the target mask.

Top module: `msi_dest_resolver`

## Requirements
- R1: With destination mode 0 (physical), a bit of `out_mask` is set exactly when that agent's physical ID equals `req_dest_id`. The value of `req_redir_hint` has no effect.
- R2: In physical mode, a destination of all ones (8'hFF) is never treated as an ID match. The result is a zero mask with `out_no_target` set, even when an agent's physical ID is 8'hFF.
- R3: With destination mode 1, redirection hint 0 and delivery code 3'b000 (fixed), `out_mask` equals the set of agents whose logical ID ANDed with `req_dest_id` is nonzero.
- R4: With destination mode 1 and redirection hint 1, exactly one bit is set. It is the matching agent whose priority class is lowest. The priority class is bits [7:4] of that agent's 8-bit priority.
- R5: Among candidates that share the lowest class, the agent with the lowest index wins. Bits [3:0] of the priority play no part in the choice.
- R6: Delivery code 3'b001 (lowest priority) triggers the same arbitration as R4, even when the redirection hint is 0.
- R7: When no agent is selected, `out_mask` is zero and `out_no_target` is high for the single cycle in which `out_valid` is high. Otherwise `out_no_target` stays low.
- R8: `out_valid` is high for exactly the one cycle after each cycle in which `req_valid` is high. `out_mask` keeps its value while no request arrives.
- R9: During and directly after reset, `out_valid`, `out_no_target` and `out_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A message is presented this cycle |
| req_dest_id | input | 8 | Destination ID or logical destination map |
| req_dest_logical | input | 1 | Destination mode: 0 physical, 1 logical |
| req_redir_hint | input | 1 | Redirection hint from the message address |
| req_dlv_mode | input | 3 | Delivery code: 3'b000 fixed, 3'b001 lowest priority |
| agent_phys_id | input | 64 | Physical ID of each agent, agent i at bits [8i+7:8i] |
| agent_log_id | input | 64 | Flat logical ID of each agent, agent i at bits [8i+7:8i] |
| agent_arb_prio | input | 64 | Arbitration priority of each agent, agent i at bits [8i+7:8i] |
| out_valid | output | 1 | Resolution result is valid |
| out_mask | output | 8 | Selected agents, bit i for agent i |
| out_no_target | output | 1 | No agent was selected |

## Verification
Every result is due exactly one clock edge after the request. The edge that samples `req_valid` also loads `out_valid`, `out_mask` and `out_no_target`, so there is no added latency for arbitration. The bench drives each request on a falling edge and holds it through one rising edge. It reads all three outputs on the next falling edge, when `out_valid` must be high. It then checks on a later falling edge that `out_valid` and `out_no_target` have returned low while `out_mask` has held its value.

// File: rtl/msi_res_pkg.sv
package msi_res_pkg;

  // Delivery codes the resolver distinguishes; every other code is routed
  // exactly like fixed delivery.
  typedef enum logic [2:0] {
    DLV_FIXED  = 3'b000,
    DLV_LOWEST = 3'b001
  } dlv_mode_e;

  localparam int unsigned MSG_ID_W = 8;
  localparam int unsigned DLV_W    = 3;

endpackage

// File: rtl/msi_match_unit.sv
module msi_match_unit #(
  parameter int unsigned N_AGENTS = 8,
  parameter int unsigned ID_W     = 8
) (
  input  logic [ID_W-1:0]          dest_id,
  input  logic                     dest_logical,
  input  logic [N_AGENTS*ID_W-1:0] phys_ids,
  input  logic [N_AGENTS*ID_W-1:0] log_ids,
  output logic [N_AGENTS-1:0]      hit
);

  localparam logic [ID_W-1:0] BCAST_ID = '1;

  logic is_bcast;
  assign is_bcast = (dest_id == BCAST_ID);

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    logic [ID_W-1:0] pid;
    logic [ID_W-1:0] lid;
    logic            phys_hit;
    logic            log_hit;

    assign pid      = phys_ids[g*ID_W +: ID_W];
    assign lid      = log_ids[g*ID_W +: ID_W];
    assign phys_hit = (pid == dest_id) && !is_bcast;
    assign log_hit  = |(lid & dest_id);
    assign hit[g]   = dest_logical ? log_hit : phys_hit;
  end

endmodule

// File: rtl/msi_lowpri_arb.sv
module msi_lowpri_arb #(
  parameter int unsigned N_AGENTS = 8,
  parameter int unsigned PRIO_W   = 8,
  parameter int unsigned CLASS_W  = 4
) (
  input  logic [N_AGENTS-1:0]        cand,
  input  logic [N_AGENTS*PRIO_W-1:0] prio,
  output logic [N_AGENTS-1:0]        grant
);

  localparam int unsigned IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;
  localparam int unsigned CLS_LO = PRIO_W - CLASS_W;

  logic [CLASS_W-1:0] best_cls;
  logic [IDX_W-1:0]   best_idx;
  logic               found;

  // One linear pass: strict less-than keeps the earliest index on a tie.
  always_comb begin
    best_cls = '1;
    best_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < N_AGENTS; i++) begin
      if (cand[i]) begin
        if (!found || (prio[i*PRIO_W + CLS_LO +: CLASS_W] < best_cls)) begin
          best_cls = prio[i*PRIO_W + CLS_LO +: CLASS_W];
          best_idx = IDX_W'(i);
          found    = 1'b1;
        end
      end
    end
  end

  always_comb begin
    grant = '0;
    if (found) begin
      grant[best_idx] = 1'b1;
    end
  end

endmodule

// File: rtl/msi_dest_resolver.sv
module msi_dest_resolver #(
  parameter int unsigned N_AGENTS = 8,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned PRIO_W   = 8,
  parameter int unsigned CLASS_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [ID_W-1:0]            req_dest_id,
  input  logic                       req_dest_logical,
  input  logic                       req_redir_hint,
  input  logic [2:0]                 req_dlv_mode,
  input  logic [N_AGENTS*ID_W-1:0]   agent_phys_id,
  input  logic [N_AGENTS*ID_W-1:0]   agent_log_id,
  input  logic [N_AGENTS*PRIO_W-1:0] agent_arb_prio,
  output logic                       out_valid,
  output logic [N_AGENTS-1:0]        out_mask,
  output logic                       out_no_target
);

  import msi_res_pkg::*;

  logic [N_AGENTS-1:0] hit;
  logic [N_AGENTS-1:0] grant;
  logic                arb_en;
  logic [N_AGENTS-1:0] sel;

  logic                valid_d, valid_q;
  logic [N_AGENTS-1:0] mask_d,  mask_q;
  logic                nt_d,    nt_q;

  msi_match_unit #(
    .N_AGENTS (N_AGENTS),
    .ID_W     (ID_W)
  ) u_match (
    .dest_id      (req_dest_id),
    .dest_logical (req_dest_logical),
    .phys_ids     (agent_phys_id),
    .log_ids      (agent_log_id),
    .hit          (hit)
  );

  msi_lowpri_arb #(
    .N_AGENTS (N_AGENTS),
    .PRIO_W   (PRIO_W),
    .CLASS_W  (CLASS_W)
  ) u_arb (
    .cand  (hit),
    .prio  (agent_arb_prio),
    .grant (grant)
  );

  // Arbitrate on a lowest-priority code, or on a logical message with the hint.
  assign arb_en = (req_dlv_mode == DLV_LOWEST) ||
                  (req_dest_logical && req_redir_hint);
  assign sel    = arb_en ? grant : hit;

  // Next-state
  always_comb begin
    valid_d = req_valid;
    mask_d  = mask_q;
    nt_d    = 1'b0;
    if (req_valid) begin
      mask_d = sel;
      nt_d   = (sel == '0);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      nt_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
      nt_q    <= nt_d;
    end
  end

  assign out_valid     = valid_q;
  assign out_mask      = mask_q;
  assign out_no_target = nt_q;

  // Assertions
  p_req_to_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  p_idle_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  p_hold_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(out_mask));

  p_notgt_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_no_target == (out_mask == '0)));

  p_notgt_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_no_target);

  p_bcast_phys_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_dest_logical && (req_dest_id == '1)) |=> out_no_target);

  p_redir_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_dest_logical && req_redir_hint) |=> $onehot0(out_mask));

  p_grant_in_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~hit) == '0);

  p_grant_if_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |-> $onehot(grant));

endmodule

// File: tb/msi_dest_resolver_test.sv
module msi_dest_resolver_test;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [7:0]   req_dest_id;
  logic         req_dest_logical;
  logic         req_redir_hint;
  logic [2:0]   req_dlv_mode;
  logic [N*8-1:0] agent_phys_id;
  logic [N*8-1:0] agent_log_id;
  logic [N*8-1:0] agent_arb_prio;
  logic         out_valid;
  logic [N-1:0] out_mask;
  logic         out_no_target;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  msi_dest_resolver uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_dest_id      (req_dest_id),
    .req_dest_logical (req_dest_logical),
    .req_redir_hint   (req_redir_hint),
    .req_dlv_mode     (req_dlv_mode),
    .agent_phys_id    (agent_phys_id),
    .agent_log_id     (agent_log_id),
    .agent_arb_prio   (agent_arb_prio),
    .out_valid        (out_valid),
    .out_mask         (out_mask),
    .out_no_target    (out_no_target)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Present one message for one cycle and check the result on the next falling edge.
  task automatic send(input logic [7:0] dest, input logic lg, input logic rh,
                      input logic [2:0] mode, input logic [N-1:0] exp_mask,
                      input string tag);
    @(negedge clk);
    req_valid        = 1'b1;
    req_dest_id      = dest;
    req_dest_logical = lg;
    req_redir_hint   = rh;
    req_dlv_mode     = mode;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " mask"}, 32'(out_mask), 32'(exp_mask));
    chk({tag, " no_target"}, 32'(out_no_target), 32'(exp_mask == '0));
  endtask

  task automatic t_reset();
    chk("R9 reset valid", 32'(out_valid), 32'd0);
    chk("R9 reset mask", 32'(out_mask), 32'd0);
    chk("R9 reset no_target", 32'(out_no_target), 32'd0);
  endtask

  task automatic t_physical();
    send(8'h13, 1'b0, 1'b0, 3'b000, 8'h08, "R1 phys rh0");
    send(8'h13, 1'b0, 1'b1, 3'b000, 8'h08, "R1 phys rh1 ignored");
    send(8'h15, 1'b0, 1'b0, 3'b001, 8'h20, "R1 phys lowest code");
    send(8'h42, 1'b0, 1'b0, 3'b000, 8'h00, "R7 phys no match");
  endtask

  task automatic t_broadcast();
    agent_phys_id[2*8 +: 8] = 8'hFF;
    send(8'hFF, 1'b0, 1'b0, 3'b000, 8'h00, "R2 phys broadcast");
    send(8'hFF, 1'b0, 1'b1, 3'b001, 8'h00, "R2 phys broadcast rh1");
    agent_phys_id[2*8 +: 8] = 8'h12;
  endtask

  task automatic t_logical_group();
    send(8'h55, 1'b1, 1'b0, 3'b000, 8'h55, "R3 logical group 55");
    send(8'h0F, 1'b1, 1'b0, 3'b000, 8'h0F, "R3 logical group 0F");
    send(8'h3F, 1'b1, 1'b0, 3'b000, 8'h3F, "R3 logical group 3F");
  endtask

  task automatic t_redirect();
    // classes by index: 7,6,3,9,3,8,2,4
    send(8'h55, 1'b1, 1'b1, 3'b000, 8'h40, "R4 redirect lowest class");
    send(8'h3F, 1'b1, 1'b1, 3'b000, 8'h04, "R5 tie lowest index, low nibble ignored");
    send(8'h80, 1'b1, 1'b1, 3'b000, 8'h80, "R4 redirect single member");
  endtask

  task automatic t_lowest_code();
    send(8'h3F, 1'b1, 1'b0, 3'b001, 8'h04, "R6 lowest code arbitrates");
    send(8'h0B, 1'b1, 1'b0, 3'b001, 8'h02, "R6 lowest code group 0B");
  endtask

  task automatic t_no_match();
    send(8'h00, 1'b1, 1'b0, 3'b000, 8'h00, "R7 logical empty");
    send(8'h00, 1'b1, 1'b1, 3'b000, 8'h00, "R7 redirect empty");
  endtask

  task automatic t_idle_hold();
    send(8'h0F, 1'b1, 1'b0, 3'b000, 8'h0F, "R8 load");
    @(negedge clk);
    chk("R8 idle valid", 32'(out_valid), 32'd0);
    chk("R8 idle mask held", 32'(out_mask), 32'h0F);
    send(8'h00, 1'b1, 1'b0, 3'b000, 8'h00, "R8 empty result");
    @(negedge clk);
    chk("R7 no_target one cycle", 32'(out_no_target), 32'd0);
    chk("R8 valid one cycle", 32'(out_valid), 32'd0);
  endtask

  initial begin
    rst_n            = 1'b0;
    req_valid        = 1'b0;
    req_dest_id      = '0;
    req_dest_logical = 1'b0;
    req_redir_hint   = 1'b0;
    req_dlv_mode     = 3'b000;
    for (int i = 0; i < N; i++) begin
      agent_phys_id[i*8 +: 8] = 8'h10 + 8'(i);
      agent_log_id[i*8 +: 8]  = 8'(1 << i);
    end
    agent_arb_prio = {8'h44, 8'h21, 8'h80, 8'h30, 8'h91, 8'h3F, 8'h62, 8'h70};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_physical();
    t_broadcast();
    t_logical_group();
    t_redirect();
    t_lowest_code();
    t_no_match();
    t_idle_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule